// File: doc/BRIEF.md
# DSP Modulo Address Generator

This block produces the X-side and Y-side data-memory addresses for a DSP datapath. Each side holds two 32-bit address pointers and one index register. Whenever a side is strobed, its selected pointer is post-updated by nothing, by two, or by the side's index. The updated value is seen one cycle later, and the address output always shows the pointer as it stood before the update.

A shared start register and end register describe a circular buffer. Two mode bits choose which side wraps inside that buffer. The wrap test is an exact match on bits 15:1 of the current pointer against the end register. On a match, bits 15:1 are reloaded from the start register and bits 31:16 are kept. A buffer therefore has to lie inside one 64 KB-aligned region. An indexed step that jumps over the end address without landing on it does not wrap.

All registers are loaded through one write port that is addressed by a 4-bit select code. Bit 0 of every stored address value is dropped, so both address outputs are always even.

Top module: `dmag_top`

## Requirements
- R1: On a synchronous active-high reset, every pointer, both index registers, the start and end registers and both mode bits are cleared. From the first cycle after reset, both address outputs and `mode_clash` are 0.
- R2: A write with `wr_en`=1 loads `wr_data` with bit 0 cleared into the register that `wr_sel` names. The codes are: 0 X pointer A, 1 X pointer B, 2 Y pointer A, 3 Y pointer B, 4 X index, 5 Y index, 6 ring start, 7 ring end. Code 8 loads the mode bits, with `wr_data` bit 0 as the X modulo enable and bit 1 as the Y modulo enable. Codes 9 to 15 change nothing.
- R3: `x_addr` shows X pointer A when `x_sel`=0 and X pointer B when `x_sel`=1. `y_addr` shows the Y pointers in the same way. Both outputs show the value before any update in that cycle, and bit 0 of each output is always 0.
- R4: When a side's update strobe is high, its step code selects the change to the chosen pointer, with wrap modulo 2^32: 0 and 3 leave it unchanged, 1 adds 2, and 2 adds that side's index register. The new value appears on the next cycle.
- R5: On an update of a pointer whose side has modulo enabled, if bits 15:1 of the pointer equal bits 15:1 of the ring end, the pointer becomes {pointer[31:16], start[15:1], 0} for any step code. For example, start 0x7008, end 0x700C and pointer 0xA5007008 give 0xA500700A, 0xA500700C and 0xA5007008 under +2 steps.
- R6: When the pointer does not match the end address, the sum is stored even if an indexed step carries it past the end, and even if the upper half-word changes.
- R7: The X mode bit enables wrapping for the X pointers. The Y mode bit enables wrapping for the Y pointers only while the X mode bit is clear. `mode_clash` is 1 exactly when both mode bits are set.
- R8: Both sides may update in the same cycle, independently. An update changes only the pointer that its side selected.
- R9: A write and an update that target the same pointer in the same cycle leave the written value. An update always uses the index, start and end values held before any write in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 4 | Register select code (see R2) |
| wr_data | input | 32 | Write data |
| x_upd | input | 1 | X side post-update strobe |
| x_sel | input | 1 | X pointer select (0 = A, 1 = B) |
| x_step | input | 2 | X step code (see R4) |
| y_upd | input | 1 | Y side post-update strobe |
| y_sel | input | 1 | Y pointer select (0 = A, 1 = B) |
| y_step | input | 2 | Y step code (see R4) |
| x_addr | output | 32 | Current X address |
| y_addr | output | 32 | Current Y address |
| mode_clash | output | 1 | Both modulo mode bits set |

## Verification
Every register in the block eventually shows up at an address output. A corrupted pointer is visible at once whenever its select input chooses it. A wrong index register shows up one cycle after an indexed step. Wrong start or end registers, or wrong mode bits, stay hidden until a pointer reaches the end address. After that they show as a missing wrap, a wrap on the wrong side, or a reload with the wrong low half-word one cycle later. The bench walks pointers repeatedly through small rings with every step code, mode setting and select combination, so such faults surface within a few cycles.

// File: rtl/dmag_pkg.sv
`timescale 1ns/1ps
package dmag_pkg;

    localparam int unsigned AW    = 32;
    localparam int unsigned HALF  = 16;
    localparam int unsigned SELW  = 4;
    localparam int unsigned PTR_N = 2;
    localparam int unsigned PSW   = $clog2(PTR_N);

    typedef logic [AW-1:0] addr_t;

    typedef enum logic [1:0] {
        STEP_KEEP  = 2'd0,
        STEP_TWO   = 2'd1,
        STEP_IDX   = 2'd2,
        STEP_KEEP2 = 2'd3
    } step_e;

    typedef enum logic [SELW-1:0] {
        WSEL_XA    = 4'd0,
        WSEL_XB    = 4'd1,
        WSEL_YA    = 4'd2,
        WSEL_YB    = 4'd3,
        WSEL_XIDX  = 4'd4,
        WSEL_YIDX  = 4'd5,
        WSEL_START = 4'd6,
        WSEL_STOP  = 4'd7,
        WSEL_MODE  = 4'd8
    } wsel_e;

    typedef struct packed {
        addr_t start;
        addr_t stop;
    } ring_t;

    typedef struct packed {
        logic x_on;
        logic y_on;
        logic clash;
    } mode_t;

    function automatic addr_t even(addr_t v);
        return {v[AW-1:1], 1'b0};
    endfunction

    function automatic logic ring_hit(addr_t p, addr_t stop);
        return p[HALF-1:1] == stop[HALF-1:1];
    endfunction

    function automatic addr_t ring_reload(addr_t p, addr_t start);
        return {p[AW-1:HALF], start[HALF-1:1], 1'b0};
    endfunction

    function automatic addr_t step_amount(step_e s, addr_t idx);
        addr_t amt;
        case (s)
            STEP_TWO: amt = addr_t'(2);
            STEP_IDX: amt = even(idx);
            default:  amt = '0;
        endcase
        return amt;
    endfunction

endpackage

// File: rtl/dmag_next.sv
`timescale 1ns/1ps
module dmag_next
    import dmag_pkg::*;
(
    input  addr_t cur,
    input  addr_t idx,
    input  step_e step,
    input  logic  mod_en,
    input  ring_t ring,
    output addr_t nxt
);
    logic  wrap;
    addr_t sum;

    always_comb begin
        wrap = mod_en && ring_hit(cur, ring.stop);
        sum  = cur + step_amount(step, idx);
        nxt  = wrap ? ring_reload(cur, ring.start) : even(sum);
    end
endmodule

// File: rtl/dmag_cfg.sv
`timescale 1ns/1ps
module dmag_cfg
    import dmag_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [SELW-1:0] wr_sel,
    input  addr_t           wr_data,
    output ring_t           ring,
    output mode_t           mode
);
    addr_t start_q, stop_q;
    logic  xm_q, ym_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            stop_q  <= '0;
            xm_q    <= 1'b0;
            ym_q    <= 1'b0;
        end else if (wr_en) begin
            if (wr_sel == WSEL_START) start_q <= even(wr_data);
            if (wr_sel == WSEL_STOP)  stop_q  <= even(wr_data);
            if (wr_sel == WSEL_MODE) begin
                xm_q <= wr_data[0];
                ym_q <= wr_data[1];
            end
        end
    end

    always_comb begin
        ring.start = start_q;
        ring.stop  = stop_q;
        mode.x_on  = xm_q;
        mode.y_on  = ym_q & ~xm_q;
        mode.clash = xm_q & ym_q;
    end
endmodule

// File: rtl/dmag_side.sv
`timescale 1ns/1ps
module dmag_side
    import dmag_pkg::*;
#(
    parameter logic [PTR_N*SELW-1:0] PTR_CODES = '0,
    parameter logic [SELW-1:0]       IDX_CODE  = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [SELW-1:0] wr_sel,
    input  addr_t           wr_data,
    input  logic            upd,
    input  logic [PSW-1:0]  sel,
    input  step_e           step,
    input  logic            mod_en,
    input  ring_t           ring,
    output addr_t           addr
);
    addr_t idx_q;
    addr_t cur;
    addr_t nxt;
    addr_t ptr_v [PTR_N];

    always_ff @(posedge clk) begin
        if (rst)                             idx_q <= '0;
        else if (wr_en && wr_sel == IDX_CODE) idx_q <= even(wr_data);
    end

    for (genvar g = 0; g < PTR_N; g++) begin : g_ptr
        addr_t q;
        logic  wr_hit;
        logic  up_hit;

        assign wr_hit = wr_en && (wr_sel == PTR_CODES[g*SELW +: SELW]);
        assign up_hit = upd && (int'(sel) == g);

        always_ff @(posedge clk) begin
            if (rst)         q <= '0;
            else if (wr_hit) q <= even(wr_data);
            else if (up_hit) q <= nxt;
        end

        assign ptr_v[g] = q;
    end

    assign cur  = ptr_v[sel];
    assign addr = cur;

    dmag_next u_next (
        .cur    (cur),
        .idx    (idx_q),
        .step   (step),
        .mod_en (mod_en),
        .ring   (ring),
        .nxt    (nxt)
    );
endmodule

// File: rtl/dmag_top.sv
`timescale 1ns/1ps
module dmag_top
    import dmag_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [3:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic        x_upd,
    input  logic        x_sel,
    input  logic [1:0]  x_step,
    input  logic        y_upd,
    input  logic        y_sel,
    input  logic [1:0]  y_step,
    output logic [31:0] x_addr,
    output logic [31:0] y_addr,
    output logic        mode_clash
);
    ring_t ring_w;
    mode_t mode_w;

    dmag_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ring    (ring_w),
        .mode    (mode_w)
    );

    dmag_side #(
        .PTR_CODES ({WSEL_XB, WSEL_XA}),
        .IDX_CODE  (WSEL_XIDX)
    ) u_xside (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .upd     (x_upd),
        .sel     (x_sel),
        .step    (step_e'(x_step)),
        .mod_en  (mode_w.x_on),
        .ring    (ring_w),
        .addr    (x_addr)
    );

    dmag_side #(
        .PTR_CODES ({WSEL_YB, WSEL_YA}),
        .IDX_CODE  (WSEL_YIDX)
    ) u_yside (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .upd     (y_upd),
        .sel     (y_sel),
        .step    (step_e'(y_step)),
        .mod_en  (mode_w.y_on),
        .ring    (ring_w),
        .addr    (y_addr)
    );

    assign mode_clash = mode_w.clash;
endmodule

// File: rtl/dmag_chk.sv
`timescale 1ns/1ps
module dmag_chk
    import dmag_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        x_upd,
    input logic        x_sel,
    input logic [1:0]  x_step,
    input logic        y_upd,
    input logic        y_sel,
    input logic [31:0] x_addr,
    input logic [31:0] y_addr,
    input logic        mode_clash,
    input mode_t       mode,
    input ring_t       ring
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (x_addr == '0 && y_addr == '0 && !mode_clash));

    assert_even_out_R3: assert property (@(posedge clk) disable iff (rst)
        (x_addr[0] == 1'b0) && (y_addr[0] == 1'b0));

    assert_add_two_R4: assert property (@(posedge clk) disable iff (rst)
        (x_upd && x_step == 2'd1 && !mode.x_on && !wr_en) ##1 (x_sel == $past(x_sel))
        |-> x_addr == $past(x_addr) + 32'd2);

    assert_x_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!x_upd && !wr_en) ##1 (x_sel == $past(x_sel)) |-> $stable(x_addr));

    assert_y_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!y_upd && !wr_en) ##1 (y_sel == $past(y_sel)) |-> $stable(y_addr));

    assert_wrap_reload_R5: assert property (@(posedge clk) disable iff (rst)
        (x_upd && mode.x_on && x_addr[HALF-1:1] == ring.stop[HALF-1:1] && !wr_en)
        ##1 (x_sel == $past(x_sel))
        |-> x_addr == {$past(x_addr[AW-1:HALF]), $past(ring.start[HALF-1:1]), 1'b0});

    assert_clash_prio_R7: assert property (@(posedge clk) disable iff (rst)
        mode_clash |-> (mode.x_on && !mode.y_on));
endmodule

bind dmag_top dmag_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .x_upd      (x_upd),
    .x_sel      (x_sel),
    .x_step     (x_step),
    .y_upd      (y_upd),
    .y_sel      (y_sel),
    .x_addr     (x_addr),
    .y_addr     (y_addr),
    .mode_clash (mode_clash),
    .mode       (mode_w),
    .ring       (ring_w)
);

// File: tb/sim_dmag_top.sv
`timescale 1ns/1ps
module sim_dmag_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        x_upd = 1'b0, x_sel = 1'b0, y_upd = 1'b0, y_sel = 1'b0;
    logic [1:0]  x_step = '0, y_step = '0;
    logic [31:0] x_addr, y_addr;
    logic        mode_clash;

    dmag_top u0 (.*);

    int total = 0;
    int bad = 0;

    logic [31:0] m_ptr [4];
    logic [31:0] m_idx [2];
    logic [31:0] m_ms, m_me;
    logic [1:0]  m_mode;
    logic [31:0] lf = 32'h1D2C_3B4A;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mnext(int s, logic [31:0] p, logic [1:0] st);
        logic on;
        on = (s == 0) ? m_mode[0] : (m_mode[1] & ~m_mode[0]);
        if (on && p[15:1] == m_me[15:1]) return {p[31:16], m_ms[15:1], 1'b0};
        case (st)
            2'd1:    return p + 32'd2;
            2'd2:    return p + m_idx[s];
            default: return p;
        endcase
    endfunction

    task automatic cyc();
        logic [31:0] np [4];
        logic [31:0] ni [2];
        logic [31:0] nms, nme, d;
        logic [1:0]  nmd;
        np = m_ptr; ni = m_idx; nms = m_ms; nme = m_me; nmd = m_mode;
        d = {wr_data[31:1], 1'b0};
        if (x_upd) np[x_sel] = mnext(0, m_ptr[x_sel], x_step);
        if (y_upd) np[2 + y_sel] = mnext(1, m_ptr[2 + y_sel], y_step);
        if (wr_en) begin
            case (wr_sel)
                4'd0, 4'd1, 4'd2, 4'd3: np[wr_sel] = d;
                4'd4: ni[0] = d;
                4'd5: ni[1] = d;
                4'd6: nms = d;
                4'd7: nme = d;
                4'd8: nmd = wr_data[1:0];
                default: ;
            endcase
        end
        @(posedge clk); #1;
        m_ptr = np; m_idx = ni; m_ms = nms; m_me = nme; m_mode = nmd;
    endtask

    task automatic check_out(string tag);
        chk(tag, x_addr, m_ptr[x_sel]);
        chk(tag, y_addr, m_ptr[2 + y_sel]);
        chk(tag, {31'd0, mode_clash}, {31'd0, m_mode[0] & m_mode[1]});
    endtask

    task automatic wr(logic [3:0] code, logic [31:0] data);
        x_upd = 0; y_upd = 0;
        wr_en = 1; wr_sel = code; wr_data = data;
        cyc();
        wr_en = 0;
    endtask

    task automatic peek_all(string tag);
        for (int s = 0; s < 2; s++) begin
            x_sel = s[0]; y_sel = s[0];
            #1;
            check_out(tag);
        end
    endtask

    task automatic xstep(logic sel, logic [1:0] st);
        x_upd = 1; x_sel = sel; x_step = st; y_upd = 0;
        cyc();
        x_upd = 0;
    endtask

    task automatic ystep(logic sel, logic [1:0] st);
        y_upd = 1; y_sel = sel; y_step = st; x_upd = 0;
        cyc();
        y_upd = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_ptr[i] = '0;
        m_idx[0] = '0; m_idx[1] = '0; m_ms = '0; m_me = '0; m_mode = '0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        #1;
        // R1 reset state
        chk("R1 x_addr", x_addr, 32'h0);
        chk("R1 y_addr", y_addr, 32'h0);
        chk("R1 clash", {31'd0, mode_clash}, 32'h0);

        // R2 writes with odd data, bit 0 dropped
        wr(4'd0, 32'h1111_0001); wr(4'd1, 32'h2222_0003);
        wr(4'd2, 32'h3333_0005); wr(4'd3, 32'h4444_0007);
        peek_all("R2 write");
        chk("R2 xa even", m_ptr[0], 32'h1111_0000);
        wr(4'd4, 32'h0000_0011); xstep(0, 2'd2);
        chk("R2 x index", x_addr, 32'h1111_0010);

        // R2 ignored codes 9..15
        for (int c = 9; c < 16; c++) begin
            wr(c[3:0], 32'hFFFF_FFFF);
            peek_all("R2 ignored code");
        end

        // R5 worked example
        wr(4'd8, 32'h1); wr(4'd6, 32'h7008); wr(4'd7, 32'h700C);
        wr(4'd0, 32'hA500_7008);
        x_sel = 0; #1;
        chk("R3 pre-update", x_addr, 32'hA500_7008);
        xstep(0, 2'd1); chk("R5 ex1", x_addr, 32'hA500_700A);
        xstep(0, 2'd1); chk("R5 ex2", x_addr, 32'hA500_700C);
        xstep(0, 2'd1); chk("R5 ex3", x_addr, 32'hA500_7008);
        // R5 wrap on step code 0 with upper bits kept
        wr(4'd1, 32'h0001_700C); xstep(1, 2'd0);
        chk("R5 hold wrap", x_addr, 32'h0001_7008);

        // R6 indexed step overshooting the end
        wr(4'd6, 32'h7000); wr(4'd7, 32'h7010); wr(4'd4, 32'h6);
        wr(4'd0, 32'h1234_700C);
        xstep(0, 2'd2); chk("R6 pass1", x_addr, 32'h1234_7012);
        xstep(0, 2'd2); chk("R6 pass2", x_addr, 32'h1234_7018);
        wr(4'd8, 32'h0); wr(4'd4, 32'h0000_0010); wr(4'd0, 32'h0000_FFF8);
        xstep(0, 2'd2); chk("R6 carry", x_addr, 32'h0001_0008);

        // R7 modes
        wr(4'd8, 32'h3); #1;
        chk("R7 clash", {31'd0, mode_clash}, 32'h1);
        wr(4'd2, 32'h0000_7010); ystep(0, 2'd1);
        chk("R7 y off in clash", y_addr, 32'h0000_7012);
        wr(4'd8, 32'h2); wr(4'd2, 32'h0000_7010); ystep(0, 2'd1);
        chk("R7 y on", y_addr, 32'h0000_7000);
        wr(4'd0, 32'h0000_7010); xstep(0, 2'd1);
        chk("R7 x off", x_addr, 32'h0000_7012);

        // R9 write beats update; update uses old index
        wr(4'd5, 32'h20); wr(4'd3, 32'h100);
        x_upd = 1; x_sel = 0; x_step = 2'd1;
        wr_en = 1; wr_sel = 4'd0; wr_data = 32'hABCD_0000;
        cyc(); wr_en = 0; x_upd = 0;
        chk("R9 write wins", x_addr, 32'hABCD_0000);
        y_upd = 1; y_sel = 1; y_step = 2'd2;
        wr_en = 1; wr_sel = 4'd5; wr_data = 32'h40;
        cyc(); wr_en = 0; y_upd = 0;
        chk("R9 old index", y_addr, 32'h120);

        // R8 R4 R5 sweep over every mode, step pair and select pair
        wr(4'd6, 32'h7000); wr(4'd7, 32'h700A);
        wr(4'd4, 32'h4); wr(4'd5, 32'h6);
        for (int md = 0; md < 4; md++) begin
            wr(4'd8, md);
            for (int i = 0; i < 4; i++) wr(i[3:0], 32'h5A00_7000);
            for (int xs = 0; xs < 4; xs++)
                for (int ys = 0; ys < 4; ys++)
                    for (int sl = 0; sl < 4; sl++) begin
                        x_upd = 1; y_upd = 1;
                        x_step = xs[1:0]; y_step = ys[1:0];
                        x_sel = sl[0]; y_sel = sl[1];
                        cyc();
                        check_out("R8 sweep");
                    end
            x_upd = 0; y_upd = 0;
            peek_all("R4 sweep end");
        end

        // R8 mixed traffic with writes in a narrow window
        for (int n = 0; n < 3000; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            x_upd = lf[0]; y_upd = lf[1];
            x_sel = lf[2]; y_sel = lf[3];
            x_step = lf[5:4]; y_step = lf[7:6];
            wr_en = (lf[10:8] == 3'd0);
            wr_sel = lf[14:11];
            wr_data = (lf[14:11] == 4'd8) ? {30'd0, lf[16:15]}
                                          : {lf[31:28], 12'h0, 16'h7000 | {11'd0, lf[20:16]}};
            cyc();
            check_out("R8 mixed");
        end
        wr_en = 0; x_upd = 0; y_upd = 0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule